// File: doc/BRIEF.md
# SD SPI Command Frame Engine

This block issues a single SD-card command in SPI mode and returns the card's answer. When it accepts a start strobe, it selects the card by driving chip select low. It then sends a six-byte frame: a start/index byte, the 32-bit argument in four bytes, and a fixed checksum byte. After the frame it keeps clocking idle bytes (0xFF) until the card returns a byte whose top bit is clear. That byte is the one-byte status answer.

The block does not shift bits itself. Each byte goes through a byte-exchange handshake with an external shifter. For commands that return a longer answer, the caller can ask for four more answer bytes. Polling stops after a fixed number of idle bytes, and the block then reports a timeout. In the normal mode it deselects the card and clocks one more idle byte before it signals completion. A keep-selected mode leaves the card selected after a successful answer, so that a data phase can follow inside the same selection.

Status bits of the answer byte, from bit 0 upward, are: idle, erase reset, illegal command, command checksum error, erase sequence error, address error, parameter error. Bit 7 is always 0.

Top module: `sdcmd_engine`

## Requirements
- R1: After reset, cs_n is 1, and xfer_req, busy, done and timeout are 0.
- R2: The first exchanged byte of a command is 0x40 OR the 6-bit index (bits 7:6 = 01), sent with cs_n low.
- R3: Bytes two to five carry the argument, most significant byte first, with cs_n low.
- R4: The sixth byte is 0x87 when the index is 8 and 0x95 for every other index.
- R5: After the frame, the block sends 0xFF. The first received byte with bit 7 = 0 is stored in resp_r1. Received bytes with bit 7 = 1 are skipped.
- R6: If POLL_LIMIT polls in a row all return bit 7 = 1, then timeout is 1 at done and resp_r1 is 0xFF. An answer on exactly the POLL_LIMIT-th poll still counts as success.
- R7: When want_extra is 1 and the card answers, four more 0xFF bytes are exchanged. Their received values fill resp_extra, with the first one in bits 31:24. After a timeout, or when want_extra is 0, resp_extra is 0.
- R8: In normal mode, once polling and any extra bytes are finished (by an answer or a timeout), cs_n goes high and one more 0xFF is exchanged with cs_n high. Then done follows, and cs_n stays high.
- R9: When keep_sel is 1 and the card answers, no trailing byte is sent and cs_n stays low after done. After a timeout, the R8 release happens anyway.
- R10: done is a one-cycle pulse, given the cycle after the last exchange is acknowledged. busy is 1 from the cycle after the start is accepted until done, and 0 while done is high.
- R11: A start while busy has no effect. The running command keeps its latched index and argument, and no second command follows.
- R12: resp_r1, resp_extra and timeout hold their values from done until the next accepted start.
- R13: xfer_req, once raised, stays high with an unchanged xfer_tx until xfer_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Start strobe; accepted only while idle |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | ARG_W | Command argument |
| want_extra | input | 1 | Collect EXTRA_BYTES answer bytes after the status byte |
| keep_sel | input | 1 | Keep the card selected after a successful answer |
| xfer_req | output | 1 | Byte exchange request to the shifter |
| xfer_tx | output | 8 | Byte to send |
| xfer_ack | input | 1 | One-cycle completion of the current exchange |
| xfer_rx | input | 8 | Byte received, valid with xfer_ack |
| cs_n | output | 1 | Chip select, active low |
| busy | output | 1 | Command in progress |
| done | output | 1 | Completion pulse |
| timeout | output | 1 | Last command found no answer |
| resp_r1 | output | 8 | Status answer byte (0xFF after timeout) |
| resp_extra | output | 8*EXTRA_BYTES | Extra answer bytes, first received most significant |

## Verification
The assertions assume that the shifter raises xfer_ack only while xfer_req is high, and for a single cycle per byte. They also assume that xfer_rx is valid in that cycle. The bench's shifter model meets these conditions. It waits a varying 0 to 2 cycles after it sees a request, raises the acknowledge for one cycle, and then drops it before it looks at the next request. Start strobes last one cycle. The bench deliberately raises one start in the middle of a command to check that the block ignores it.

// File: rtl/sdcmd_pkg.sv
// Shared types and constants for the SD SPI command frame engine.
// Assumes: byte-wide exchanges, MSB-first argument ordering.
package sdcmd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FRAME,
        ST_POLL,
        ST_EXTRA,
        ST_RELEASE
    } sdcmd_state_e;

    localparam logic [7:0] FILL_BYTE   = 8'hFF;
    localparam logic [7:0] CRC_GENERIC = 8'h95;
    localparam logic [7:0] CRC_IFCOND  = 8'h87;
    localparam logic [5:0] IFCOND_IDX  = 6'd8;
    localparam logic [1:0] START_BITS  = 2'b01;
endpackage

// File: rtl/sdcmd_frame_mux.sv
// Selects the outgoing command frame byte for a given position.
// Position 0 is the start/index byte, positions 1..ARG_W/8 are argument
// bytes (most significant first), and the last position is the fixed checksum.
// Assumes: ARG_W is a multiple of 8; SEL_W can hold ARG_W/8+1.
module sdcmd_frame_mux
    import sdcmd_pkg::*;
#(
    parameter int ARG_W = 32,
    parameter int SEL_W = 3
) (
    input  logic [SEL_W-1:0] sel,
    input  logic [5:0]       idx,
    input  logic [ARG_W-1:0] arg,
    output logic [7:0]       byte_o
);
    localparam int ARG_BYTES = ARG_W / 8;
    localparam int LAST_POS  = ARG_BYTES + 1;

    logic [7:0] crc_byte;

    // Pick the checksum constant from the command index.
    always_comb crc_byte = (idx == IFCOND_IDX) ? CRC_IFCOND : CRC_GENERIC;

    // Map the frame position to its byte.
    always_comb begin
        byte_o = FILL_BYTE;
        if (sel == '0) begin
            byte_o = {START_BITS, idx};
        end else if (sel == SEL_W'(LAST_POS)) begin
            byte_o = crc_byte;
        end else begin
            for (int k = 1; k <= ARG_BYTES; k++) begin
                if (sel == SEL_W'(k)) byte_o = arg[(ARG_BYTES-k)*8 +: 8];
            end
        end
    end
endmodule

// File: rtl/sdcmd_poll_ctr.sv
// Counts answer polls and flags the last permitted one.
// Assumes: LIMIT >= 2; clr dominates step.
module sdcmd_poll_ctr #(
    parameter int LIMIT = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    output logic last
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt;

    // Advance once per completed poll; saturate at the final slot.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (step && !last) begin
            cnt <= cnt + CW'(1);
        end
    end

    // Final-poll indicator.
    always_comb last = (cnt == CW'(LIMIT - 1));

    // The counter never runs past the final slot while polls continue (R6).
    p_poll_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        step && last && !clr |=> last || clr)
        else $error("poll counter ran past its limit");
endmodule

// File: rtl/sdcmd_extra_cap.sv
// Captures the extra answer bytes into byte lanes; lane 0 is the first
// received and lands in the most significant position.
// Assumes: wr is a single-cycle strobe per byte; clr precedes each command.
module sdcmd_extra_cap #(
    parameter int NB    = 4,
    parameter int SEL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr,
    input  logic [SEL_W-1:0]  lane,
    input  logic [7:0]        din,
    output logic [NB*8-1:0]   q
);
    for (genvar i = 0; i < NB; i++) begin : g_lane
        logic [7:0] lane_q;

        // Load this lane when its index is written; clear at command start.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                lane_q <= '0;
            end else if (wr && lane == SEL_W'(i)) begin
                lane_q <= din;
            end
        end

        assign q[(NB-1-i)*8 +: 8] = lane_q;
    end
endmodule

// File: rtl/sdcmd_engine.sv
// SD SPI command frame engine: frames one command, polls for the status
// answer, optionally collects extra answer bytes, and manages chip select
// with a trailing idle byte. The bit shifter is external and reached
// through a request/acknowledge byte exchange.
// Assumes: xfer_ack is a one-cycle pulse only while xfer_req is high.
module sdcmd_engine
    import sdcmd_pkg::*;
#(
    parameter int ARG_W       = 32,
    parameter int EXTRA_BYTES = 4,
    parameter int POLL_LIMIT  = 5000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [5:0]               cmd_idx,
    input  logic [ARG_W-1:0]         cmd_arg,
    input  logic                     want_extra,
    input  logic                     keep_sel,
    output logic                     xfer_req,
    output logic [7:0]               xfer_tx,
    input  logic                     xfer_ack,
    input  logic [7:0]               xfer_rx,
    output logic                     cs_n,
    output logic                     busy,
    output logic                     done,
    output logic                     timeout,
    output logic [7:0]               resp_r1,
    output logic [EXTRA_BYTES*8-1:0] resp_extra
);
    localparam int FRAME_BYTES = ARG_W / 8 + 2;
    localparam int IDX_N       = (FRAME_BYTES > EXTRA_BYTES) ? FRAME_BYTES : EXTRA_BYTES;
    localparam int IW          = $clog2(IDX_N);

    sdcmd_state_e     state;
    logic [IW-1:0]    pos;
    logic [5:0]       cmd_q;
    logic [ARG_W-1:0] arg_q;
    logic             extra_q;
    logic             keep_q;
    logic             sel_n_q;
    logic             done_q;
    logic             to_q;
    logic [7:0]       r1_q;
    logic [7:0]       frame_byte;
    logic             accept;
    logic             poll_last;
    logic             answered;

    // A start counts only when the engine is idle.
    always_comb accept = start && (state == ST_IDLE);

    // A polled byte with a clear top bit is the status answer.
    always_comb answered = !xfer_rx[7];

    sdcmd_frame_mux #(.ARG_W(ARG_W), .SEL_W(IW)) u_mux (
        .sel    (pos),
        .idx    (cmd_q),
        .arg    (arg_q),
        .byte_o (frame_byte)
    );

    sdcmd_poll_ctr #(.LIMIT(POLL_LIMIT)) u_poll (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state != ST_POLL),
        .step  (state == ST_POLL && xfer_ack),
        .last  (poll_last)
    );

    sdcmd_extra_cap #(.NB(EXTRA_BYTES), .SEL_W(IW)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .wr    (state == ST_EXTRA && xfer_ack),
        .lane  (pos),
        .din   (xfer_rx),
        .q     (resp_extra)
    );

    // Command sequencer: frame, poll, extras, release, completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            pos     <= '0;
            cmd_q   <= '0;
            arg_q   <= '0;
            extra_q <= 1'b0;
            keep_q  <= 1'b0;
            sel_n_q <= 1'b1;
            done_q  <= 1'b0;
            to_q    <= 1'b0;
            r1_q    <= '0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        cmd_q   <= cmd_idx;
                        arg_q   <= cmd_arg;
                        extra_q <= want_extra;
                        keep_q  <= keep_sel;
                        to_q    <= 1'b0;
                        sel_n_q <= 1'b0;
                        pos     <= '0;
                        state   <= ST_FRAME;
                    end
                end
                ST_FRAME: begin
                    if (xfer_ack) begin
                        if (pos == IW'(FRAME_BYTES - 1)) begin
                            pos   <= '0;
                            state <= ST_POLL;
                        end else begin
                            pos <= pos + IW'(1);
                        end
                    end
                end
                ST_POLL: begin
                    if (xfer_ack) begin
                        if (answered) begin
                            r1_q <= xfer_rx;
                            if (extra_q) begin
                                pos   <= '0;
                                state <= ST_EXTRA;
                            end else if (keep_q) begin
                                done_q <= 1'b1;
                                state  <= ST_IDLE;
                            end else begin
                                sel_n_q <= 1'b1;
                                state   <= ST_RELEASE;
                            end
                        end else if (poll_last) begin
                            r1_q    <= FILL_BYTE;
                            to_q    <= 1'b1;
                            sel_n_q <= 1'b1;
                            state   <= ST_RELEASE;
                        end
                    end
                end
                ST_EXTRA: begin
                    if (xfer_ack) begin
                        if (pos == IW'(EXTRA_BYTES - 1)) begin
                            pos <= '0;
                            if (keep_q) begin
                                done_q <= 1'b1;
                                state  <= ST_IDLE;
                            end else begin
                                sel_n_q <= 1'b1;
                                state   <= ST_RELEASE;
                            end
                        end else begin
                            pos <= pos + IW'(1);
                        end
                    end
                end
                ST_RELEASE: begin
                    if (xfer_ack) begin
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Exchange request and byte selection.
    always_comb begin
        xfer_req = (state != ST_IDLE);
        xfer_tx  = (state == ST_FRAME) ? frame_byte : FILL_BYTE;
    end

    // Output drive.
    always_comb begin
        cs_n    = sel_n_q;
        busy    = (state != ST_IDLE);
        done    = done_q;
        timeout = to_q;
        resp_r1 = r1_q;
    end

    // The card stays selected while frame and poll bytes move (R2, R5).
    p_sel_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req && (state == ST_FRAME || state == ST_POLL) |-> !cs_n)
        else $error("chip select high during frame or poll");

    // A pending request keeps its byte until acknowledged (R13).
    p_req_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req && !xfer_ack |=> xfer_req && $stable(xfer_tx))
        else $error("request dropped or byte changed before ack");

    // done lasts a single cycle and never overlaps busy (R10).
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("done wider than one cycle");
    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy)
        else $error("done while busy");

    // A timeout always reports the all-ones status byte (R6).
    p_timeout_ff_r6: assert property (@(posedge clk) disable iff (!rst_n)
        timeout && !busy |-> resp_r1 == FILL_BYTE)
        else $error("timeout without 0xFF status");

    // Normal-mode completion leaves the card deselected (R8).
    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done && !keep_q |-> cs_n)
        else $error("chip select low at normal completion");

    // Latched command is untouched by starts while busy (R11).
    p_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cmd_q) && $stable(arg_q))
        else $error("command latch changed while busy");

    // Results hold while idle and no start arrives (R12).
    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start |=> $stable(resp_r1) && $stable(timeout) && $stable(resp_extra))
        else $error("result changed while idle");
endmodule

// File: tb/sdcmd_engine_test.sv
`timescale 1ns/1ps
module sdcmd_engine_test;
    localparam int LIMIT = 24;

    typedef struct {
        logic [7:0] tx;
        logic       cs;
        logic [7:0] rx;
        int         tag;
    } xfer_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [5:0]  cmd_idx = '0;
    logic [31:0] cmd_arg = '0;
    logic        want_extra = 1'b0;
    logic        keep_sel = 1'b0;
    logic        xfer_req;
    logic [7:0]  xfer_tx;
    logic        xfer_ack = 1'b0;
    logic [7:0]  xfer_rx = 8'hFF;
    logic        cs_n;
    logic        busy;
    logic        done;
    logic        timeout;
    logic [7:0]  resp_r1;
    logic [31:0] resp_extra;

    int n_checks = 0;
    int n_fail   = 0;
    int n_xfer   = 0;
    xfer_item_t exp_q[$];

    always #2 clk = ~clk;

    sdcmd_engine #(.ARG_W(32), .EXTRA_BYTES(4), .POLL_LIMIT(LIMIT)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_idx(cmd_idx),
        .cmd_arg(cmd_arg), .want_extra(want_extra), .keep_sel(keep_sel),
        .xfer_req(xfer_req), .xfer_tx(xfer_tx), .xfer_ack(xfer_ack),
        .xfer_rx(xfer_rx), .cs_n(cs_n), .busy(busy), .done(done),
        .timeout(timeout), .resp_r1(resp_r1), .resp_extra(resp_extra)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    task automatic push(input logic [7:0] tx, input logic cs, input logic [7:0] rx, input int tag);
        xfer_item_t it;
        it.tx = tx; it.cs = cs; it.rx = rx; it.tag = tag;
        exp_q.push_back(it);
    endtask

    // Shifter model and scoreboard monitor: pops one expected item per exchange.
    initial begin
        int wait_n = 0;
        bit in_wait = 0;
        logic [7:0] tx0 = '0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                xfer_ack = 1'b0;
                in_wait = 0;
            end else if (xfer_ack) begin
                xfer_ack = 1'b0;
            end else if (xfer_req) begin
                if (!in_wait) begin
                    in_wait = 1;
                    tx0 = xfer_tx;
                    wait_n = n_xfer % 3;
                end
                if (wait_n > 0) begin
                    wait_n--;
                end else begin
                    chk(xfer_tx == tx0, "R13", "byte changed while pending", {24'd0, xfer_tx}, {24'd0, tx0});
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R11", "unexpected exchange", {24'd0, xfer_tx}, 32'd0);
                        xfer_rx = 8'hFF;
                    end else begin
                        xfer_item_t it;
                        it = exp_q.pop_front();
                        n_checks++;
                        if (xfer_tx !== it.tx || cs_n !== it.cs) begin
                            n_fail++;
                            $display("FAIL R%0d exchange %0d actual tx=%h cs_n=%b expected tx=%h cs_n=%b",
                                     it.tag, n_xfer, xfer_tx, cs_n, it.tx, it.cs);
                        end
                        xfer_rx = it.rx;
                    end
                    xfer_ack = 1'b1;
                    in_wait = 0;
                    n_xfer++;
                end
            end
        end
    end

    // Driver: queues expected exchanges, issues the command, checks results.
    task automatic run_cmd(input logic [5:0] c, input logic [31:0] a, input logic ex,
                           input logic kp, input int resp_at, input logic [7:0] r1v,
                           input logic [31:0] exv, input bit mid);
        bit ok = (resp_at > 0 && resp_at <= LIMIT);
        int npoll = ok ? resp_at : LIMIT;
        bit rel = !(ok && kp);
        bit seen = 0;
        logic [7:0] r1e = ok ? r1v : 8'hFF;
        logic [31:0] exe = (ok && ex) ? exv : 32'd0;

        push({2'b01, c}, 1'b0, 8'hFF, 2);                              // R2
        for (int k = 0; k < 4; k++) push(a[31-8*k -: 8], 1'b0, 8'hFF, 3); // R3
        push((c == 6'd8) ? 8'h87 : 8'h95, 1'b0, 8'hFF, 4);            // R4
        for (int p = 1; p <= npoll; p++)                               // R5, R6
            push(8'hFF, 1'b0, (ok && p == resp_at) ? r1v : (8'h80 | 8'(p)), ok ? 5 : 6);
        if (ok && ex)                                                  // R7
            for (int k = 0; k < 4; k++) push(8'hFF, 1'b0, exv[31-8*k -: 8], 7);
        if (rel) push(8'hFF, 1'b1, 8'hFF, 8);                          // R8, R9

        @(negedge clk);
        cmd_idx = c; cmd_arg = a; want_extra = ex; keep_sel = kp; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R10", "busy after start", {31'd0, busy}, 32'd1);
        if (mid) begin
            repeat (7) @(negedge clk);
            cmd_idx = ~c; cmd_arg = ~a; start = 1'b1;                  // R11
            @(negedge clk);
            start = 1'b0;
        end
        for (int t = 0; t < 20000 && !seen; t++) begin
            if (done) seen = 1;
            else @(negedge clk);
        end
        chk(seen, "R10", "done seen", {31'd0, seen}, 32'd1);
        chk(resp_r1 == r1e, ok ? "R5" : "R6", "status byte", {24'd0, resp_r1}, {24'd0, r1e});
        chk(timeout == !ok, "R6", "timeout flag", {31'd0, timeout}, {31'd0, !ok});
        chk(resp_extra == exe, "R7", "extra bytes", resp_extra, exe);
        chk(busy == 1'b0, "R10", "busy at done", {31'd0, busy}, 32'd0);
        chk(cs_n == rel, rel ? "R8" : "R9", "chip select at done", {31'd0, cs_n}, {31'd0, rel});
        chk(exp_q.size() == 0, "R11", "pending expected exchanges", exp_q.size(), 32'd0);
        @(negedge clk);
        chk(done == 1'b0, "R10", "done width", {31'd0, done}, 32'd0);
        cmd_idx = 6'h2A; cmd_arg = 32'h0BAD_F00D; want_extra = ~ex; keep_sel = ~kp;
        repeat (8) @(negedge clk);
        chk(resp_r1 == r1e && timeout == !ok && resp_extra == exe, "R12", "results held",
            {23'd0, timeout, resp_r1}, {23'd0, !ok, r1e});
        chk(xfer_req == 1'b0, "R11", "no second command", {31'd0, xfer_req}, 32'd0);
        chk(cs_n == rel, rel ? "R8" : "R9", "chip select held", {31'd0, cs_n}, {31'd0, rel});
    endtask

    // Watchdog: a hang counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R10 watchdog actual=hang expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    // Main sequence.
    initial begin
        repeat (4) @(negedge clk);
        chk(cs_n == 1'b1 && xfer_req == 1'b0 && busy == 1'b0 && done == 1'b0 && timeout == 1'b0,
            "R1", "reset outputs", {27'd0, cs_n, xfer_req, busy, done, timeout}, 32'h10);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n == 1'b1 && xfer_req == 1'b0 && busy == 1'b0, "R1", "after reset release",
            {29'd0, cs_n, xfer_req, busy}, 32'h4);

        run_cmd(6'd0,  32'h0000_0000, 1'b0, 1'b0, 1,     8'h01, 32'd0,         1'b0);
        run_cmd(6'd8,  32'h0000_01AA, 1'b1, 1'b0, 3,     8'h01, 32'h0000_01AA, 1'b0);
        run_cmd(6'd17, 32'h1234_5678, 1'b0, 1'b0, LIMIT, 8'h00, 32'd0,         1'b0);
        run_cmd(6'd55, 32'hFFFF_0000, 1'b1, 1'b1, 0,     8'h00, 32'hDEAD_0001, 1'b0);
        run_cmd(6'd9,  32'h0000_0000, 1'b0, 1'b1, 2,     8'h00, 32'd0,         1'b0);
        run_cmd(6'd24, 32'hDEAD_BEEF, 1'b0, 1'b0, 5,     8'h7E, 32'd0,         1'b1);
        run_cmd(6'd58, 32'hA5C3_0F96, 1'b1, 1'b1, 1,     8'h00, 32'hC0FF_8000, 1'b0);
        run_cmd(6'd41, 32'h4000_0000, 1'b0, 1'b0, LIMIT + 1, 8'h00, 32'd0,     1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule